// File: doc/BRIEF.md
# Split-Width Nonlinear Mixer (16-bit)

This block is a purely combinational 16-bit keyed mixing function, meant to be reused inside a larger round function of a compact block cipher datapath. It splits the data word into an unequal 9-bit half and 7-bit half. Each half passes through its own nonlinear substitution, and the two halves are cross-coupled. A 16-bit subkey is folded in between two substitution layers.

Both substitution boxes are computed in logic and not stored in a memory. Each one is a cube map over a small binary field followed by a constant XOR. Because the cube is a permutation in a field of odd degree, each box is invertible. Whenever a 7-bit value feeds the 9-bit side it is widened by two leading zeros. Whenever a 9-bit value feeds the 7-bit side it loses its two top bits. The block has no clock, no state and no reset, and the caller places registers around it.

Top module: `nonlinear_mix16`

## Requirements
- R1: The data input splits as wide half = data_i[15:7] (9 bits) and narrow half = data_i[6:0] (7 bits). The key splits as narrow subkey = key_i[15:9] (7 bits) and wide subkey = key_i[8:0] (9 bits).
- R2: The 7-bit substitution returns v^3 in GF(2^7) modulo x^7+x+1, XORed with the constant 7'h15.
- R3: The 9-bit substitution returns v^3 in GF(2^9) modulo x^9+x^4+1, XORed with the constant 9'h0B3.
- R4: A 7-bit value combined into the 9-bit side is zero-extended by prepending two zero bits, so the top two bits of the wide result come only from the 9-bit substitution.
- R5: A 9-bit value combined into the 7-bit side is truncated by dropping its two most significant bits.
- R6: One layer maps (w, n) to w' = S9(w) ^ zext(n) and n' = S7(n) ^ trunc(w'). The block applies one layer, then XORs the wide subkey into w and the narrow subkey into n, then applies a second layer.
- R7: result_o = {final narrow half, final wide half}, which puts the 7-bit part in bits [15:9] and the 9-bit part in bits [8:0].
- R8: The output is a combinational function of data_i and key_i alone. It follows an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 16 | Data word to mix |
| key_i | input | 16 | Subkey folded in between the two layers |
| result_o | output | 16 | Mixed word, narrow part on top |

## Verification
A wrong field polynomial or constant in one substitution box changes result_o for most inputs at once. The change shows up in the same time step, because no register hides it. A swapped split, a missing zero-extension or a truncation that keeps the wrong bits causes a mismatch only for patterns that drive the affected bits. For that reason the data word is swept through all 65536 values, and so is the key, each against an arithmetic model. Targeted vectors that set only one half, plus an input change between clock edges, separate the field mapping and the purely combinational timing.

// File: rtl/nlmix_pkg.sv
package nlmix_pkg;

    localparam int unsigned WIDE_W   = 9;
    localparam int unsigned NARROW_W = 7;
    localparam int unsigned WORD_W   = WIDE_W + NARROW_W;
    localparam int unsigned EXT_W    = WIDE_W - NARROW_W;

    localparam logic [9:0] POLY_NARROW = 10'h083;
    localparam logic [9:0] POLY_WIDE   = 10'h211;

    typedef struct packed {
        logic [WIDE_W-1:0]   wide;
        logic [NARROW_W-1:0] narrow;
    } halves_t;

    function automatic logic [WIDE_W-1:0] zext_n2w(input logic [NARROW_W-1:0] v);
        return {{EXT_W{1'b0}}, v};
    endfunction

    function automatic logic [NARROW_W-1:0] trunc_w2n(input logic [WIDE_W-1:0] v);
        return v[NARROW_W-1:0];
    endfunction

    // Shift-and-add multiply in GF(2^w), w <= 9, field polynomial given in full.
    function automatic logic [8:0] gf_mul(input logic [8:0] a, input logic [8:0] b,
                                          input int unsigned w, input logic [9:0] poly);
        logic [9:0] x;
        logic [8:0] acc;
        acc = '0;
        x   = {1'b0, a};
        for (int i = 0; i < 9; i++) begin
            if ((i < w) && b[i]) acc ^= x[8:0];
            x = {x[8:0], 1'b0};
            if (x[w]) x ^= poly;
        end
        return acc;
    endfunction

    function automatic logic [8:0] gf_cube(input logic [8:0] a, input int unsigned w,
                                           input logic [9:0] poly);
        return gf_mul(gf_mul(a, a, w, poly), a, w, poly);
    endfunction

endpackage

// File: rtl/nlmix_sbox.sv
module nlmix_sbox
    import nlmix_pkg::*;
#(
    parameter int unsigned     WIDTH = 7,
    parameter logic [9:0]      POLY  = 10'h083,
    parameter logic [WIDTH-1:0] XOR_C = '0
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [8:0] cube_full;

    always_comb begin
        cube_full = gf_cube(9'(din), WIDTH, POLY);
        dout      = cube_full[WIDTH-1:0] ^ XOR_C;
        if (!$isunknown(din)) begin
            // R2 / R3: zero is the only field element whose cube is zero
            p_zero_to_const_r2_r3: assert ((din != '0) || (dout == XOR_C))
                else $error("sbox: zero input did not map to the constant");
            p_nonzero_avoids_const_r2_r3: assert ((din == '0) || (dout != XOR_C))
                else $error("sbox: nonzero input collided with the zero image");
        end
    end

endmodule

// File: rtl/nlmix_stage.sv
module nlmix_stage
    import nlmix_pkg::*;
#(
    parameter logic [NARROW_W-1:0] C_NARROW = 7'h15,
    parameter logic [WIDE_W-1:0]   C_WIDE   = 9'h0B3
) (
    input  halves_t in_h,
    output halves_t out_h
);

    logic [WIDE_W-1:0]   s_wide;
    logic [NARROW_W-1:0] s_narrow;

    nlmix_sbox #(.WIDTH(WIDE_W), .POLY(POLY_WIDE), .XOR_C(C_WIDE)) u_box_wide (
        .din  (in_h.wide),
        .dout (s_wide)
    );

    nlmix_sbox #(.WIDTH(NARROW_W), .POLY(POLY_NARROW), .XOR_C(C_NARROW)) u_box_narrow (
        .din  (in_h.narrow),
        .dout (s_narrow)
    );

    always_comb begin
        out_h.wide   = s_wide ^ zext_n2w(in_h.narrow);
        out_h.narrow = s_narrow ^ trunc_w2n(out_h.wide);
        if (!$isunknown({s_wide, s_narrow, in_h})) begin
            // R4: the widened narrow value never reaches the two top bits
            p_ext_top_clear_r4: assert (out_h.wide[WIDE_W-1:NARROW_W] == s_wide[WIDE_W-1:NARROW_W])
                else $error("stage: zero-extension disturbed upper bits");
            // R5: only the low bits of the new wide value reach the narrow side
            p_trunc_low_only_r5: assert ((out_h.narrow ^ s_narrow) == out_h.wide[NARROW_W-1:0])
                else $error("stage: truncation used wrong bits");
        end
    end

endmodule

// File: rtl/nonlinear_mix16.sv
module nonlinear_mix16
    import nlmix_pkg::*;
#(
    parameter int unsigned         NUM_LAYERS = 2,
    parameter logic [NARROW_W-1:0] C_NARROW   = 7'h15,
    parameter logic [WIDE_W-1:0]   C_WIDE     = 9'h0B3
) (
    input  logic [15:0] data_i,
    input  logic [15:0] key_i,
    output logic [15:0] result_o
);

    localparam int unsigned LAST = NUM_LAYERS - 1;

    halves_t layer_in  [NUM_LAYERS];
    halves_t layer_out [NUM_LAYERS];
    halves_t key_h;

    // R1: key narrow subkey on top, wide subkey below; data wide half on top
    assign key_h.narrow = key_i[WORD_W-1:WIDE_W];
    assign key_h.wide   = key_i[WIDE_W-1:0];

    generate
        for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_layer
            if (g == 0) begin : g_first
                assign layer_in[g].wide   = data_i[WORD_W-1:NARROW_W];
                assign layer_in[g].narrow = data_i[NARROW_W-1:0];
            end else begin : g_keyed
                assign layer_in[g] = layer_out[g-1] ^ key_h;
            end
            nlmix_stage #(.C_NARROW(C_NARROW), .C_WIDE(C_WIDE)) u_stage (
                .in_h  (layer_in[g]),
                .out_h (layer_out[g])
            );
        end
    endgenerate

    // R7: narrow part in the upper bits
    assign result_o = {layer_out[LAST].narrow, layer_out[LAST].wide};

endmodule

// File: tb/nonlinear_mix16_tb_top.sv
module nonlinear_mix16_tb_top;

    localparam int C7 = 'h15;
    localparam int C9 = 'h0B3;
    localparam int P7 = 'h083;
    localparam int P9 = 'h211;

    logic        clk;
    logic [15:0] data_i;
    logic [15:0] key_i;
    logic [15:0] result_o;
    int          n_checks;
    int          n_errors;
    int          cycles;
    bit          done;

    nonlinear_mix16 dut_i (.data_i(data_i), .key_i(key_i), .result_o(result_o));

    initial clk = 1'b0;
    always #5 clk = ~clk;

    function automatic int clmul(int a, int b, int w);
        int r = 0;
        for (int i = 0; i < w; i++) if (((b >> i) & 1) != 0) r ^= (a << i);
        return r;
    endfunction

    function automatic int reduce(int p, int w, int poly);
        for (int i = 2 * w - 2; i >= w; i--)
            if (((p >> i) & 1) != 0) p ^= (poly << (i - w));
        return p;
    endfunction

    function automatic int cube(int v, int w, int poly);
        int sq = reduce(clmul(v, v, w), w, poly);
        return reduce(clmul(sq, v, w), w, poly);
    endfunction

    function automatic int s7(int v); return cube(v, 7, P7) ^ C7; endfunction
    function automatic int s9(int v); return cube(v, 9, P9) ^ C9; endfunction

    function automatic logic [15:0] model(int d, int k);
        int w = (d >> 7) & 'h1FF;
        int n = d & 'h7F;
        w = s9(w) ^ n;             // zero-extended narrow value
        n = s7(n) ^ (w & 'h7F);    // truncated wide value
        w ^= k & 'h1FF;
        n ^= (k >> 9) & 'h7F;
        begin
            int w2 = s9(w) ^ n;
            int n2 = s7(n) ^ (w2 & 'h7F);
            return 16'((n2 << 9) | w2);
        end
    endfunction

    task automatic check(input string req);
        logic [15:0] exp = model(int'(data_i), int'(key_i));
        n_checks++;
        if (result_o !== exp) begin
            n_errors++;
            $display("FAIL %s data=%h key=%h actual=%h expected=%h",
                     req, data_i, key_i, result_o, exp);
        end
    endtask

    task automatic vec(input logic [15:0] d, input logic [15:0] k, input string req);
        @(posedge clk);
        data_i = d;
        key_i  = k;
        @(negedge clk);
        check(req);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 190000 && !done) begin
            n_errors++;
            $display("FAIL watchdog R8 actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        n_checks = 0; n_errors = 0; cycles = 0; done = 0;
        data_i = '0; key_i = '0;
        // R2 R3: all-zero input exposes both constants through the full path
        vec(16'h0000, 16'h0000, "R2 R3 R6 zero input");
        vec(16'hFFFF, 16'hFFFF, "R6 all ones");
        // R4: only the narrow half set
        vec(16'h007F, 16'h0000, "R4 narrow-only data");
        // R5: only the wide half set
        vec(16'hFF80, 16'h0000, "R5 wide-only data");
        // R1: key narrow subkey alone, then wide subkey alone
        vec(16'h0000, 16'hFE00, "R1 narrow subkey");
        vec(16'h0000, 16'h01FF, "R1 wide subkey");
        vec(16'h8001, 16'h0100, "R1 R7 split boundary");
        // R8: change input mid-cycle, no edge in between
        @(posedge clk);
        #2 data_i = 16'h1357; key_i = 16'h2468;
        #1 check("R8 combinational response");
        #1 key_i = 16'h9BDF;
        #1 check("R8 combinational response");
        // R6 R7: sweep every data word with a fixed key
        for (int i = 0; i < 65536; i++) vec(16'(i), 16'hA5C3, "R6 R7 data sweep");
        // R1 R6: sweep every key with a fixed data word
        for (int i = 0; i < 65536; i++) vec(16'h5A3C, 16'(i), "R1 R6 key sweep");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule